// File: doc/BRIEF.md
# Data Cache Line Coherence State Machine

This block holds the coherence state of a single data cache line and moves it among three states (invalid, valid, dirty). The moves are driven by processor reads and writes, two maintenance commands (invalidate and push), and snoop hits. A per-access mode input selects writethrough or copyback behaviour for the page being touched. Tag comparison, data storage and victim choice stay outside; the surrounding cache supplies a hit indication and acts on the allocate and writeback outputs.

In the cycle it is presented, each event is resolved to exactly one action by a fixed priority. `alloc_o` and `writeback_o` are combinational and are valid in that same cycle, while the line still shows its old state. The new state appears on `state_o` after the next rising clock edge. The block can be replicated once per line, or one copy can serve as a shared next-state function.

Top module: `line_state_fsm`

## Requirements
- R1: After an active-low asynchronous reset the line is invalid. `state_o` is encoded as 0 = invalid, 1 = valid, 2 = dirty, and the value 3 never appears.
- R2: A read miss in either mode asserts `alloc_o` in the same cycle and leaves the line valid. If the old line was dirty, `writeback_o` is also asserted in that cycle.
- R3: In copyback mode (`copyback_i`=1), a write miss asserts `alloc_o` and leaves the line dirty. A dirty old line also raises `writeback_o`.
- R4: In copyback mode, a write hit on a valid line makes it dirty. Read hits and write hits on a dirty line keep it dirty without asserting either output.
- R5: In writethrough mode (`copyback_i`=0), a write miss leaves the state unchanged and does not assert `alloc_o`. A write hit on a valid line keeps it valid.
- R6: An invalidate makes the line invalid and never asserts `writeback_o`, even when the line was dirty.
- R7: A push makes the line invalid. It asserts `writeback_o` for that one cycle exactly when the line was dirty.
- R8: A snoop hit makes the line invalid and asserts neither `writeback_o` nor `alloc_o`.
- R9: When several events arrive together, only the highest takes effect, in this order: snoop hit, push, invalidate, write, read.
- R10: A read hit on a valid line leaves it valid and asserts neither output.
- R11: When the line is invalid, `hit_i` is ignored and any access is treated as a miss.
- R12: With no event presented, the state holds and both outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Processor read access |
| wr_i | input | 1 | Processor write access |
| hit_i | input | 1 | Tag of the access matches this line |
| copyback_i | input | 1 | 1 = copyback page, 0 = writethrough page |
| inval_i | input | 1 | Invalidate maintenance command |
| push_i | input | 1 | Push maintenance command |
| snoop_hit_i | input | 1 | Snooped bus access matched this line |
| state_o | output | 2 | Current line state (0 invalid, 1 valid, 2 dirty) |
| writeback_o | output | 1 | Dirty data must be written back this cycle |
| alloc_o | output | 1 | Line is refilled from memory this cycle |

## Verification
Directed sequences first walk each state through every event in both modes. They pair each access kind with a hit and a miss so that allocation, dirtying and writeback can be told apart. Collision cases then present several events at once, which exposes any wrong priority order. Constrained random traffic follows, with maintenance and snoop events kept rare so the line spends long stretches in the dirty and valid states. This makes the random part probe mode mixing, and `hit_i` on an invalid line, from every state.

// File: rtl/line_state_pkg.sv
package line_state_pkg;
  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    LS_INV = 2'd0,
    LS_VAL = 2'd1,
    LS_DRT = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_SNOOP,
    EV_PUSH,
    EV_INVAL,
    EV_WR_HIT,
    EV_WR_MISS,
    EV_RD_HIT,
    EV_RD_MISS
  } line_ev_e;
endpackage

// File: rtl/line_event_dec.sv
module line_event_dec
  import line_state_pkg::*;
#(
  parameter bit WR_FIRST = 1'b1
) (
  input  line_st_e cur_st_i,
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     hit_i,
  input  logic     inval_i,
  input  logic     push_i,
  input  logic     snoop_hit_i,
  output line_ev_e ev_o
);
  logic     hit_eff;
  line_ev_e rd_ev, wr_ev, acc_ev;

  // an invalid line can never hit
  assign hit_eff = hit_i && (cur_st_i != LS_INV);
  assign rd_ev   = hit_eff ? EV_RD_HIT : EV_RD_MISS;
  assign wr_ev   = hit_eff ? EV_WR_HIT : EV_WR_MISS;

  generate
    if (WR_FIRST) begin : g_wr_first
      always_comb begin
        if (wr_i)      acc_ev = wr_ev;
        else if (rd_i) acc_ev = rd_ev;
        else           acc_ev = EV_IDLE;
      end
    end else begin : g_rd_first
      always_comb begin
        if (rd_i)      acc_ev = rd_ev;
        else if (wr_i) acc_ev = wr_ev;
        else           acc_ev = EV_IDLE;
      end
    end
  endgenerate

  always_comb begin
    if (snoop_hit_i)  ev_o = EV_SNOOP;
    else if (push_i)  ev_o = EV_PUSH;
    else if (inval_i) ev_o = EV_INVAL;
    else              ev_o = acc_ev;
  end
endmodule

// File: rtl/line_next_state.sv
module line_next_state
  import line_state_pkg::*;
(
  input  line_st_e cur_st_i,
  input  line_ev_e ev_i,
  input  logic     copyback_i,
  output line_st_e nxt_st_o,
  output logic     wb_o,
  output logic     alloc_o
);
  logic is_dirty;
  assign is_dirty = (cur_st_i == LS_DRT);

  always_comb begin
    nxt_st_o = cur_st_i;
    wb_o     = 1'b0;
    alloc_o  = 1'b0;
    unique case (ev_i)
      EV_SNOOP: nxt_st_o = LS_INV;
      EV_PUSH: begin
        nxt_st_o = LS_INV;
        wb_o     = is_dirty;
      end
      EV_INVAL: nxt_st_o = LS_INV; // dirty data dropped
      EV_RD_MISS: begin
        nxt_st_o = LS_VAL;
        alloc_o  = 1'b1;
        wb_o     = is_dirty;
      end
      EV_WR_MISS: begin
        if (copyback_i) begin
          nxt_st_o = LS_DRT;
          alloc_o  = 1'b1;
          wb_o     = is_dirty;
        end
      end
      EV_WR_HIT: begin
        if (copyback_i) nxt_st_o = LS_DRT;
      end
      EV_RD_HIT, EV_IDLE: nxt_st_o = cur_st_i;
      default: nxt_st_o = cur_st_i;
    endcase
  end
endmodule

// File: rtl/line_state_fsm.sv
module line_state_fsm
  import line_state_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               hit_i,
  input  logic               copyback_i,
  input  logic               inval_i,
  input  logic               push_i,
  input  logic               snoop_hit_i,
  output logic [STATE_W-1:0] state_o,
  output logic               writeback_o,
  output logic               alloc_o
);
  line_st_e st_q, st_d;
  line_ev_e ev;

  line_event_dec #(.WR_FIRST(1'b1)) u_dec (
    .cur_st_i   (st_q),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .hit_i      (hit_i),
    .inval_i    (inval_i),
    .push_i     (push_i),
    .snoop_hit_i(snoop_hit_i),
    .ev_o       (ev)
  );

  line_next_state u_nxt (
    .cur_st_i  (st_q),
    .ev_i      (ev),
    .copyback_i(copyback_i),
    .nxt_st_o  (st_d),
    .wb_o      (writeback_o),
    .alloc_o   (alloc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LS_INV;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/line_state_chk.sv
module line_state_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic       wr_i,
  input logic       copyback_i,
  input logic       inval_i,
  input logic       push_i,
  input logic       snoop_hit_i,
  input logic [1:0] state_o,
  input logic       writeback_o,
  input logic       alloc_o
);
  logic maint;
  assign maint = snoop_hit_i || push_i || inval_i;

  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3) else $error("illegal state"); // R1

  AST_SNOOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_hit_i |=> state_o == 2'd0) else $error("snoop"); // R8

  AST_MAINT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i || inval_i) |=> state_o == 2'd0) else $error("maint"); // R6

  AST_PUSH_DIRTY_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !snoop_hit_i && state_o == 2'd2) |-> writeback_o) else $error("push wb"); // R7

  AST_WB_FROM_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    writeback_o |-> state_o == 2'd2) else $error("wb"); // R7

  AST_ALLOC_ACCESS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_o |-> ((rd_i || wr_i) && !maint)) else $error("alloc"); // R9

  AST_WT_NO_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !copyback_i && !maint && state_o != 2'd2) |=> state_o != 2'd2)
    else $error("wt dirty"); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i && !maint) |=> $stable(state_o)) else $error("idle"); // R12
endmodule

bind line_state_fsm line_state_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .copyback_i (copyback_i),
  .inval_i    (inval_i),
  .push_i     (push_i),
  .snoop_hit_i(snoop_hit_i),
  .state_o    (state_o),
  .writeback_o(writeback_o),
  .alloc_o    (alloc_o)
);

// File: tb/line_state_fsm_test.sv
`timescale 1ns/1ps
module line_state_fsm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd = 0, wr = 0, hit = 0, cb = 0, inv = 0, psh = 0, snp = 0;
  logic [1:0] st;
  logic       wb, al;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;
  logic [1:0] exp_st = 2'd0;

  always #2 clk = ~clk;

  line_state_fsm uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .hit_i(hit),
    .copyback_i(cb), .inval_i(inv), .push_i(psh), .snoop_hit_i(snp),
    .state_o(st), .writeback_o(wb), .alloc_o(al)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic model(input logic [1:0] s, output logic [1:0] ns,
                       output logic ewb, output logic eal, output string tag);
    logic h;
    h   = hit && (s != 2'd0);          // R11
    ns  = s; ewb = 0; eal = 0; tag = "R12";
    if (snp)      begin ns = 0; tag = "R8"; end
    else if (psh) begin ns = 0; ewb = (s == 2); tag = "R7"; end
    else if (inv) begin ns = 0; tag = "R6"; end
    else if (wr) begin
      if (h) begin
        if (cb) ns = 2;
        tag = cb ? "R4" : "R5";
      end else if (cb) begin
        ns = 2; eal = 1; ewb = (s == 2); tag = "R3";
      end else tag = "R5";
    end else if (rd) begin
      if (h) tag = (s == 2) ? "R4" : "R10";
      else begin ns = 1; eal = 1; ewb = (s == 2); tag = "R2"; end
    end
    if ((rd || wr) && !snp && !psh && !inv && hit && s == 0) tag = "R11";
    if ((snp && (psh || inv || rd || wr)) || (!snp && (psh || inv) && (rd || wr))) tag = "R9";
  endtask

  task automatic step(input logic r, w, h, c, i, p, s);
    logic [1:0] ns; logic ewb, eal; string tag;
    @(negedge clk);
    chk("R1", "state", st, exp_st);
    rd = r; wr = w; hit = h; cb = c; inv = i; psh = p; snp = s;
    #1;
    model(exp_st, ns, ewb, eal, tag);
    chk(tag, "writeback", wb, ewb);
    chk(tag, "alloc", al, eal);
    exp_st = ns;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    #1;
    chk("R1", "reset state", st, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R11: hit ignored on invalid, R2 read miss
    step(1,0,1,1,0,0,0);
    step(1,0,1,0,0,0,0);            // R10
    step(0,1,1,0,0,0,0);            // R5 wt write hit stays valid
    step(0,1,1,1,0,0,0);            // R4 valid->dirty
    step(1,0,1,1,0,0,0);            // R4 read hit dirty
    step(0,1,1,1,0,0,0);            // R4 write hit dirty
    step(0,0,0,0,0,0,0);            // R12
    step(1,0,0,0,0,0,0);            // R2 dirty victim
    step(0,1,0,1,0,0,0);            // R3 miss -> dirty
    step(0,1,0,1,0,0,0);            // R3 dirty victim wb
    step(0,0,0,0,0,1,0);            // R7 push dirty
    step(0,1,0,0,0,0,0);            // R5 wt write miss no alloc
    step(0,1,0,1,0,0,0);            // R3
    step(0,0,0,0,1,0,0);            // R6 inval dirty, no wb
    step(1,0,0,0,0,0,0);            // R2
    step(0,0,0,0,0,1,0);            // R7 push valid no wb
    step(0,1,0,1,0,0,0);
    step(0,0,0,0,0,0,1);            // R8 snoop dirty
    step(0,1,0,1,0,0,0);
    step(0,1,1,1,1,1,1);            // R9 snoop beats all
    step(0,1,0,1,0,0,0);
    step(1,1,0,1,1,1,0);            // R9 push beats inval/access
    step(1,1,0,1,0,0,0);            // R9 write beats read
    step(1,1,0,1,1,0,0);            // R9 inval beats access
    void'($urandom(32'h1ee7));
    for (int k = 0; k < 4000; k++) begin
      step($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
           $urandom_range(0,1), $urandom_range(0,11) == 0,
           $urandom_range(0,11) == 0, $urandom_range(0,15) == 0);
    end
    step(0,0,0,0,0,0,0);
    @(negedge clk);
    chk("R12", "final state", st, exp_st);
    finish_run();
  end
endmodule